// File: doc/BRIEF.md
# Program memory bank address mapper

This block translates CPU addresses for a cartridge holding an 8-bit processor's program. The upper half of the CPU address space, 0x8000 to 0xFFFF, is cut into two 16 KiB slots that are mapped onto pages of a larger program ROM. The lower slot (0x8000 to 0xBFFF) follows a small bank register. Software loads that register by writing anywhere from 0xF000 to 0xFFFF. The upper slot (0xC000 to 0xFFFF) always points at the final ROM page, whatever the size of the fitted ROM. An 8 KiB work RAM is decoded at 0x6000 to 0x7FFF.

The block is purely combinational apart from the bank register. It produces a page number and an in-page offset for the ROM, a select, write enable and offset for the RAM, and a read-data multiplexer that returns zero for addresses it does not own. The number of ROM pages is an input, so one netlist serves boards with different ROM sizes.

Top module: `prg_bank_mapper`

## Requirements
- R1: For any address with bit 15 set, rom_offset equals address bits 13:0 and the slot is chosen by address bit 14 (0 = lower, 1 = upper); on a read (cpu_we low) rom_sel is 1.
- R2: A write (cpu_we high) to any address whose bits 15:12 equal 0xF loads cpu_wdata bits 2:0 into the bank register; lower-slot reads from the next clock cycle use that value as the page.
- R3: In the upper slot, rom_page equals page_count minus one, regardless of any bank register writes.
- R4: After synchronous reset the bank register is 0, so a lower-slot read selects page 0.
- R5: For addresses 0x6000 to 0x7FFF, ram_sel is 1, ram_offset equals the address minus 0x6000, and ram_we equals cpu_we; for every other address ram_sel and ram_we are 0.
- R6: On a read, cpu_rdata returns rom_rdata in 0x8000 to 0xFFFF, ram_rdata in 0x6000 to 0x7FFF, and 0 for all other addresses; during a write cpu_rdata is 0.
- R7: A lower-slot page is the bank register value modulo page_count; a page_count of 0 gives page 0 in both slots.
- R8: Writes to 0x8000 to 0xEFFF leave the bank register unchanged, and rom_sel is 0 whenever cpu_we is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, high for a write cycle |
| page_count | input | PCNT_W (5) | Number of 16 KiB pages in the fitted ROM |
| rom_rdata | input | 8 | Data returned by the ROM |
| ram_rdata | input | 8 | Data returned by the work RAM |
| rom_sel | output | 1 | ROM read select |
| rom_page | output | PAGE_W (4) | ROM page number for the current slot |
| rom_offset | output | 14 | Offset within the page |
| ram_sel | output | 1 | Work RAM select |
| ram_we | output | 1 | Work RAM write enable |
| ram_offset | output | 13 | Offset within the work RAM |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
The bench uses the default parameters: a 3-bit bank register, 4-bit page numbers and a 5-bit page count. With these, ROMs of 1 to 16 pages can be set. Page counts below eight make the modulo wrap of bank values visible. Counts of eight and above show the raw bank value in the lower slot, and a count of 16 puts the fixed upper page at 15, the widest value of rom_page.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int CPU_AW     = 16;
    localparam int ROM_OFF_W  = 14;
    localparam int RAM_OFF_W  = 13;
    localparam logic [CPU_AW-1:0] RAM_BASE = 16'h6000;

    typedef enum logic [1:0] {
        WIN_NONE   = 2'd0,
        WIN_RAM    = 2'd1,
        WIN_ROM_LO = 2'd2,
        WIN_ROM_HI = 2'd3
    } window_t;

    typedef struct packed {
        window_t               win;
        logic [ROM_OFF_W-1:0]  rom_off;
        logic [RAM_OFF_W-1:0]  ram_off;
    } decode_t;

    function automatic decode_t decode_addr(input logic [CPU_AW-1:0] a);
        decode_t      d;
        logic [CPU_AW-1:0] rel;
        rel       = a - RAM_BASE;
        d.rom_off = a[ROM_OFF_W-1:0];
        d.ram_off = rel[RAM_OFF_W-1:0];
        if (a[15])
            d.win = a[14] ? WIN_ROM_HI : WIN_ROM_LO;
        else if (a[14:13] == 2'b11)
            d.win = WIN_RAM;
        else
            d.win = WIN_NONE;
        return d;
    endfunction

    function automatic logic hits_bank_reg(input logic [CPU_AW-1:0] a, input logic we);
        return we && (a[15:12] == 4'hF);
    endfunction

endpackage

// File: rtl/mapper_bank_reg.sv
module mapper_bank_reg #(
    parameter int BANK_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [BANK_W-1:0] bank
);
    always_ff @(posedge clk) begin
        if (rst)
            bank <= '0;
        else if (load)
            bank <= wdata[BANK_W-1:0];
    end
endmodule

// File: rtl/mapper_page_sel.sv
module mapper_page_sel #(
    parameter int BANK_W = 3,
    parameter int PAGE_W = 4,
    parameter int PCNT_W = 5
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [PCNT_W-1:0] page_count,
    input  logic              upper,
    output logic [PAGE_W-1:0] page
);
    localparam int MW     = (BANK_W > PCNT_W) ? BANK_W : PCNT_W;
    localparam int STEPS  = 1 << BANK_W;

    // Reduce the bank value by repeated subtraction; the bank is narrow,
    // so the unrolled chain stays short and needs no divider.
    function automatic logic [MW-1:0] wrap_bank(input logic [BANK_W-1:0] v,
                                                input logic [PCNT_W-1:0] n);
        logic [MW-1:0] r;
        r = MW'(v);
        for (int i = 0; i < STEPS; i++) begin
            if (r >= MW'(n))
                r = r - MW'(n);
        end
        return r;
    endfunction

    logic [PCNT_W-1:0] last_page;
    logic [MW-1:0]     low_page;

    always_comb begin
        last_page = page_count - PCNT_W'(1);
        low_page  = wrap_bank(bank, page_count);
        if (page_count == '0)
            page = '0;
        else if (upper)
            page = PAGE_W'(last_page);
        else
            page = PAGE_W'(low_page);
    end
endmodule

// File: rtl/mapper_read_mux.sv
module mapper_read_mux
    import mapper_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  window_t           win,
    input  logic              we,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (!we) begin
            unique case (win)
                WIN_ROM_LO, WIN_ROM_HI: rdata = rom_rdata;
                WIN_RAM:                rdata = ram_rdata;
                default:                rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
    import mapper_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BANK_W = 3,
    parameter int PAGE_W = 4,
    parameter int PCNT_W = PAGE_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic [DATA_W-1:0]    cpu_wdata,
    input  logic                 cpu_we,
    input  logic [PCNT_W-1:0]    page_count,
    input  logic [DATA_W-1:0]    rom_rdata,
    input  logic [DATA_W-1:0]    ram_rdata,
    output logic                 rom_sel,
    output logic [PAGE_W-1:0]    rom_page,
    output logic [ROM_OFF_W-1:0] rom_offset,
    output logic                 ram_sel,
    output logic                 ram_we,
    output logic [RAM_OFF_W-1:0] ram_offset,
    output logic [DATA_W-1:0]    cpu_rdata
);
    decode_t           dec;
    logic [BANK_W-1:0] bank;
    logic              bank_load;

    always_comb begin
        dec       = decode_addr(cpu_addr);
        bank_load = hits_bank_reg(cpu_addr, cpu_we);
    end

    mapper_bank_reg #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .load  (bank_load),
        .wdata (cpu_wdata),
        .bank  (bank)
    );

    mapper_page_sel #(.BANK_W(BANK_W), .PAGE_W(PAGE_W), .PCNT_W(PCNT_W)) u_page (
        .bank       (bank),
        .page_count (page_count),
        .upper      (dec.win == WIN_ROM_HI),
        .page       (rom_page)
    );

    mapper_read_mux #(.DATA_W(DATA_W)) u_rmux (
        .win       (dec.win),
        .we        (cpu_we),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .rdata     (cpu_rdata)
    );

    always_comb begin
        rom_sel    = (dec.win == WIN_ROM_LO || dec.win == WIN_ROM_HI) && !cpu_we;
        rom_offset = dec.rom_off;
        ram_sel    = (dec.win == WIN_RAM);
        ram_we     = ram_sel && cpu_we;
        ram_offset = dec.ram_off;
    end
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
    parameter int DATA_W = 8,
    parameter int BANK_W = 3,
    parameter int PAGE_W = 4,
    parameter int PCNT_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_we,
    input logic [PCNT_W-1:0] page_count,
    input logic [DATA_W-1:0] ram_rdata,
    input logic              rom_sel,
    input logic [PAGE_W-1:0] rom_page,
    input logic              ram_sel,
    input logic [12:0]       ram_offset,
    input logic [DATA_W-1:0] cpu_rdata
);
    localparam int NOWRAP = 1 << BANK_W;

    // R3: upper slot tied to the last page
    assert_last_page_R3: assert property (@(posedge clk) disable iff (rst)
        (rom_sel && cpu_addr[14] && page_count != '0)
            |-> (PCNT_W'(rom_page) == page_count - PCNT_W'(1)));

    // R2: a bank write shows up in the lower slot one cycle later
    assert_bank_load_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(cpu_we && cpu_addr[15:12] == 4'hF) && rom_sel && !cpu_addr[14]
            && page_count >= PCNT_W'(NOWRAP))
            |-> (rom_page == PAGE_W'($past(cpu_wdata[BANK_W-1:0]))));

    // R4: right after reset the lower slot reads page 0
    assert_reset_page_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && rom_sel && !cpu_addr[14]) |-> (rom_page == '0));

    // R8: lower-slot page holds while no bank write occurs
    assert_bank_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b10 && $past(cpu_addr[15:14] == 2'b10)
            && !$past(cpu_we && cpu_addr[15:12] == 4'hF) && $stable(page_count))
            |-> $stable(rom_page));

    // R8: ROM never selected on a write
    assert_rom_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_we |-> !rom_sel);

    // R5: RAM select only inside its window, offset from the base
    assert_ram_window_R5: assert property (@(posedge clk) disable iff (rst)
        ram_sel |-> (cpu_addr >= 16'h6000 && cpu_addr <= 16'h7FFF
                     && {3'b000, ram_offset} == cpu_addr - 16'h6000));

    // R6: unowned reads return zero, RAM reads pass RAM data
    assert_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (!rom_sel && !ram_sel) |-> (cpu_rdata == '0));

    assert_read_ram_R6: assert property (@(posedge clk) disable iff (rst)
        (ram_sel && !cpu_we) |-> (cpu_rdata == ram_rdata));
endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .PAGE_W(PAGE_W), .PCNT_W(PCNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_we     (cpu_we),
    .page_count (page_count),
    .ram_rdata  (ram_rdata),
    .rom_sel    (rom_sel),
    .rom_page   (rom_page),
    .ram_sel    (ram_sel),
    .ram_offset (ram_offset),
    .cpu_rdata  (cpu_rdata)
);

// File: tb/prg_bank_mapper_tb.sv
module prg_bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_we = 1'b0;
    logic [4:0]  page_count = 5'd5;
    logic [7:0]  rom_rdata = 8'h00;
    logic [7:0]  ram_rdata = 8'h00;
    logic        rom_sel, ram_sel, ram_we;
    logic [3:0]  rom_page;
    logic [13:0] rom_offset;
    logic [12:0] ram_offset;
    logic [7:0]  cpu_rdata;

    int checks = 0;
    int errors = 0;
    int bank_m = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prg_bank_mapper u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .page_count(page_count), .rom_rdata(rom_rdata),
        .ram_rdata(ram_rdata), .rom_sel(rom_sel), .rom_page(rom_page),
        .rom_offset(rom_offset), .ram_sel(ram_sel), .ram_we(ram_we),
        .ram_offset(ram_offset), .cpu_rdata(cpu_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h addr=%h", req, act, exp, cpu_addr);
        end
    endtask

    function automatic int exp_page(input logic [15:0] a, input int bank, input int n);
        if (n == 0) return 0;
        if (a[14]) return n - 1;
        return bank % n;
    endfunction

    // Compare all outputs for the inputs just driven, then update the bank model.
    task automatic cycle_check();
        logic in_ram;
        int   rd;
        #1;
        in_ram = (cpu_addr[15:13] == 3'b011);
        if (cpu_addr[15]) begin
            check("R1 offset", rom_offset, cpu_addr[13:0]);
            check("R1/R8 rom_sel", rom_sel, !cpu_we);
            if (cpu_addr[14])
                check("R3 upper page", rom_page, exp_page(cpu_addr, bank_m, page_count));
            else
                check(page_count < 8 ? "R7 wrapped page" : "R2 lower page",
                      rom_page, exp_page(cpu_addr, bank_m, page_count));
        end else begin
            check("R6 rom_sel outside", rom_sel, 0);
        end
        check("R5 ram_sel", ram_sel, in_ram);
        check("R5 ram_we", ram_we, in_ram && cpu_we);
        if (in_ram) check("R5 ram offset", ram_offset, cpu_addr - 16'h6000);
        rd = 0;
        if (!cpu_we) rd = cpu_addr[15] ? rom_rdata : (in_ram ? ram_rdata : 0);
        check("R6 rdata", cpu_rdata, rd);
        if (cpu_we && cpu_addr[15:12] == 4'hF) bank_m = cpu_wdata[2:0];
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [15:0] a, input logic we, input logic [7:0] d);
        cpu_addr  = a;
        cpu_we    = we;
        cpu_wdata = d;
        rom_rdata = 8'($urandom);
        ram_rdata = 8'($urandom);
        cycle_check();
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int counts[8] = '{1, 2, 3, 5, 7, 8, 12, 16};
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        bank_m = 0;
        // R4: reset state
        page_count = 5'd5;
        drive(16'h8000, 1'b0, 8'h00);
        check("R4 reset page", rom_page, 0);
        // R3: upper slot at last page
        page_count = 5'd3;
        drive(16'hC000, 1'b0, 8'h00);
        // R2: load bank with 0x0F -> 7
        drive(16'hF000, 1'b1, 8'h0F);
        page_count = 5'd16;
        drive(16'h8123, 1'b0, 8'h00);
        check("R2 bank 7 visible", rom_page, 7);
        // R7: 7 mod 3 = 1
        page_count = 5'd3;
        drive(16'hBFFF, 1'b0, 8'h00);
        check("R7 7 mod 3", rom_page, 1);
        // R8: writes below 0xF000 ignored
        drive(16'h8000, 1'b1, 8'h05);
        drive(16'hEFFF, 1'b1, 8'h02);
        page_count = 5'd16;
        drive(16'h9000, 1'b0, 8'h00);
        check("R8 bank kept", rom_page, 7);
        // R3: bank write does not move the upper slot
        drive(16'hFFFF, 1'b1, 8'h03);
        drive(16'hFFFF, 1'b0, 8'h00);
        check("R3 after write", rom_page, 15);
        check("R1 top offset", rom_offset, 14'h3FFF);
        // R5/R6 window edges
        drive(16'h5FFF, 1'b0, 8'h00);
        drive(16'h6000, 1'b1, 8'hAB);
        drive(16'h7FFF, 1'b0, 8'h00);
        check("R5 last ram offset", ram_offset, 13'h1FFF);
        drive(16'h0000, 1'b0, 8'h00);
        // R7: page count zero
        page_count = 5'd0;
        drive(16'h8000, 1'b0, 8'h00);
        drive(16'hC000, 1'b0, 8'h00);
        check("R7 zero count", rom_page, 0);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            logic        we;
            if (i % 250 == 0) page_count = 5'(counts[$urandom % 8]);
            a  = 16'($urandom);
            if ($urandom % 8 == 0) a[15:12] = 4'hF;
            else if ($urandom % 4 == 0) a[15:13] = 3'b011;
            we = ($urandom % 4 == 0);
            drive(a, we, 8'($urandom));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule